// File: doc/BRIEF.md
# Display Power-Up Reset Sequencer

This block takes a small display controller of the command-set kind from an unknown state to a known, freshly reset state before any pixel traffic is sent. It sits between the boot control logic and a separate bus engine that serialises single command bytes and returns read data. The block only issues requests through a generic request/complete handshake. The physical link, supply rails and backlight belong to other blocks.

A start request comes in one of two flavours. An unconditional start always performs the full sequence. First the active-low reset pin is pulsed (when the board has one). Then the block waits for the controller to recover, sends the soft-reset command and waits for the controller to settle. A conditional start first asks the controller for its power-mode byte. If the display already reports itself awake and showing an image, the whole reset is skipped, so a picture left by an earlier boot stage does not flicker. Every delay is given in time and converted to clock cycles through the `CLK_HZ` parameter. Here cycles(t) = ceil(CLK_HZ × t), with a minimum of 1. At the end the block gives a one-cycle completion pulse with a 2-bit outcome code.

Top module: `disp_pwrup_seq`

## Requirements
- R1: After reset, `rstPinN` is 1, `busy` is 0, `cmdReq` is 0 and `donePulse` is 0. `rstPinN` is 1 whenever `busy` is 0.
- R2: On a full sequence with `RESET_PIN_PRESENT`=1, `rstPinN` is driven to 0 for exactly cycles(20 µs) clock cycles, starting at the edge that accepts `start`.
- R3: After `rstPinN` returns to 1, the block waits exactly cycles(120 ms) cycles before raising `cmdReq` for the soft reset.
- R4: The soft reset is a write request (`cmdRead`=0) with `cmdByte`=0x01. `cmdReq` and `cmdByte` are held until `cmdDone` is seen.
- R5: After the edge that accepts a successful soft-reset completion, `donePulse` rises on the S-th following edge. S = cycles(5 ms) when `RESET_PIN_PRESENT`=1 and S = cycles(120 ms) when it is 0.
- R6: With `condMode`=1 and `READ_PATH_PRESENT`=1, the block first issues a read request (`cmdRead`=1) with `cmdByte`=0x0A. If the returned byte, with bits 7, 1 and 0 masked off, equals 0x1C, the block finishes with status ALREADY_ON. It then sends no soft reset and leaves `rstPinN` at 1.
- R7: If the power-mode read returns `cmdErr`=1 or a byte that fails the R6 test, the full sequence of R2 to R5 follows.
- R8: With `READ_PATH_PRESENT`=0, a conditional start issues no read and performs the full sequence.
- R9: `doneStatus` is valid with `donePulse`: 0 = reset performed, 1 = already on, 2 = soft-reset command failed. A soft-reset completion with `cmdErr`=1 ends the sequence on the next edge with status 2, with no settle wait.
- R10: `donePulse` lasts exactly one cycle. `busy` is 1 from the edge that accepts `start` until the edge that raises `donePulse`.
- R11: A `start` that arrives while `busy` is 1 has no effect. It causes no extra request, no extra pulse and no change of mode.
- R12: With `RESET_PIN_PRESENT`=0, `rstPinN` stays 1 throughout and the soft reset follows `start` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled when idle |
| condMode | input | 1 | 1 = check power mode first and skip if running |
| busy | output | 1 | Sequence in progress |
| donePulse | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | Outcome code, valid with donePulse |
| rstPinN | output | 1 | Active-low controller reset pin |
| cmdReq | output | 1 | Command request to the bus engine |
| cmdRead | output | 1 | 1 = read one byte, 0 = write command |
| cmdByte | output | 8 | Command code |
| cmdDone | input | 1 | One-cycle completion from the bus engine |
| cmdErr | input | 1 | Completion carried an error |
| cmdRdData | input | 8 | Byte returned by a read |

## Verification
The bench sweeps all 256 power-mode readback values on a slow-clock instance. A compare that forgets to mask the don't-care bits, or that masks the wrong ones, either resets a running display or skips a sleeping one. The pulse width, recovery gap and settle time are counted cycle by cycle, so an off-by-one in the timer load or a swapped settle constant shows up as a wrong count. A failed read must fall through to a full reset, and a failed soft reset must end at once with status 2. A second start during a long wait must leave the request count and pulse count unchanged. A design that re-arms on it would issue a read or a second completion.

// File: rtl/dps_pkg.sv
package dps_pkg;

  localparam longint unsigned PIN_PULSE_US    = 20;
  localparam longint unsigned PIN_RECOVER_US  = 120_000;
  localparam longint unsigned SETTLE_PIN_US   = 5_000;
  localparam longint unsigned SETTLE_NOPIN_US = 120_000;

  localparam logic [7:0] CMD_GET_PWR_MODE = 8'h0A;
  localparam logic [7:0] CMD_SOFT_RESET   = 8'h01;
  localparam logic [7:0] PM_DONT_CARE     = 8'h83;
  localparam logic [7:0] PM_RUNNING       = 8'h1C;

  typedef enum logic [1:0] {
    ST_RESET_DONE = 2'd0,
    ST_ALREADY_ON = 2'd1,
    ST_CMD_ERROR  = 2'd2
  } seqStatus_t;

  typedef struct packed {
    logic loadPulse;
    logic loadPinWait;
    logic loadSettle;
    logic count;
    logic pinLow;
    logic pinHigh;
    logic selRead;
    logic selSoft;
  } dpStrobe_t;

  function automatic longint unsigned usToCycles(input longint unsigned hz,
                                                 input longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999_999) / 64'd1_000_000;
    return (c == 64'd0) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/dps_datapath.sv
module dps_datapath
  import dps_pkg::*;
#(
  parameter int unsigned CLK_HZ            = 1_000_000,
  parameter bit          RESET_PIN_PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic [7:0] rdData,
  output logic       tmrLast,
  output logic       readMatch,
  output logic [7:0] cmdByte,
  output logic       rstPinN
);

  localparam longint unsigned PULSE_CYC   = usToCycles(CLK_HZ, PIN_PULSE_US);
  localparam longint unsigned RECOVER_CYC = usToCycles(CLK_HZ, PIN_RECOVER_US);
  localparam longint unsigned SETTLE_CYC  = RESET_PIN_PRESENT ?
                                            usToCycles(CLK_HZ, SETTLE_PIN_US) :
                                            usToCycles(CLK_HZ, SETTLE_NOPIN_US);
  localparam longint unsigned MAX_CYC     = (RECOVER_CYC > SETTLE_CYC) ? RECOVER_CYC : SETTLE_CYC;
  localparam int              TMR_W       = $clog2(MAX_CYC + 1);

  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (stb.loadPulse) begin
      tmr <= TMR_W'(PULSE_CYC);
    end else if (stb.loadPinWait) begin
      tmr <= TMR_W'(RECOVER_CYC);
    end else if (stb.loadSettle) begin
      tmr <= TMR_W'(SETTLE_CYC);
    end else if (stb.count && tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign tmrLast = (tmr == TMR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPinN <= 1'b1;
    end else if (stb.pinLow) begin
      rstPinN <= 1'b0;
    end else if (stb.pinHigh) begin
      rstPinN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdByte <= '0;
    end else if (stb.selRead) begin
      cmdByte <= CMD_GET_PWR_MODE;
    end else if (stb.selSoft) begin
      cmdByte <= CMD_SOFT_RESET;
    end
  end

  assign readMatch = ((rdData & ~PM_DONT_CARE) == PM_RUNNING);

  generate
    if (!RESET_PIN_PRESENT) begin : g_noPinChk
      AST_NO_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
        rstPinN); // R12
    end
  endgenerate

  AST_TMR_NO_LOAD_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.loadPulse, stb.loadPinWait, stb.loadSettle}) <= 1); // R3

endmodule

// File: rtl/dps_control.sv
module dps_control
  import dps_pkg::*;
#(
  parameter bit RESET_PIN_PRESENT = 1'b1,
  parameter bit READ_PATH_PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       condMode,
  input  logic       cmdDone,
  input  logic       cmdErr,
  input  logic       tmrLast,
  input  logic       readMatch,
  output dpStrobe_t  stb,
  output logic       cmdReq,
  output logic       cmdRead,
  output logic       busy,
  output logic       donePulse,
  output logic [1:0] doneStatus
);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_PINLOW, S_PINWAIT, S_SOFT, S_SETTLE
  } seqState_t;

  seqState_t  st, nxt;
  seqStatus_t finStat, statQ;
  logic       fin, goReset, doneQ;

  always_comb begin
    nxt     = st;
    stb     = '0;
    fin     = 1'b0;
    finStat = ST_RESET_DONE;
    goReset = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        if (condMode && READ_PATH_PRESENT) begin
          nxt         = S_READ;
          stb.selRead = 1'b1;
        end else begin
          goReset = 1'b1;
        end
      end
      S_READ: if (cmdDone) begin
        if (!cmdErr && readMatch) begin
          fin     = 1'b1;
          finStat = ST_ALREADY_ON;
          nxt     = S_IDLE;
        end else begin
          goReset = 1'b1;
        end
      end
      S_PINLOW: begin
        stb.count = 1'b1;
        if (tmrLast) begin
          stb.pinHigh     = 1'b1;
          stb.loadPinWait = 1'b1;
          nxt             = S_PINWAIT;
        end
      end
      S_PINWAIT: begin
        stb.count = 1'b1;
        if (tmrLast) begin
          stb.selSoft = 1'b1;
          nxt         = S_SOFT;
        end
      end
      S_SOFT: if (cmdDone) begin
        if (cmdErr) begin
          fin     = 1'b1;
          finStat = ST_CMD_ERROR;
          nxt     = S_IDLE;
        end else begin
          stb.loadSettle = 1'b1;
          nxt            = S_SETTLE;
        end
      end
      S_SETTLE: begin
        stb.count = 1'b1;
        if (tmrLast) begin
          fin = 1'b1;
          nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (goReset) begin
      if (RESET_PIN_PRESENT) begin
        stb.pinLow    = 1'b1;
        stb.loadPulse = 1'b1;
        nxt           = S_PINLOW;
      end else begin
        stb.selSoft = 1'b1;
        nxt         = S_SOFT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_IDLE;
      doneQ <= 1'b0;
      statQ <= ST_RESET_DONE;
    end else begin
      st    <= nxt;
      doneQ <= fin;
      if (fin) statQ <= finStat;
    end
  end

  assign cmdReq     = (st == S_READ) || (st == S_SOFT);
  assign cmdRead    = (st == S_READ);
  assign busy       = (st != S_IDLE);
  assign donePulse  = doneQ;
  assign doneStatus = statQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R10
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && !cmdDone) |=> (cmdReq && $stable(cmdRead))); // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy); // R10

endmodule

// File: rtl/disp_pwrup_seq.sv
module disp_pwrup_seq
  import dps_pkg::*;
#(
  parameter int unsigned CLK_HZ            = 1_000_000,
  parameter bit          RESET_PIN_PRESENT = 1'b1,
  parameter bit          READ_PATH_PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       condMode,
  output logic       busy,
  output logic       donePulse,
  output logic [1:0] doneStatus,
  output logic       rstPinN,
  output logic       cmdReq,
  output logic       cmdRead,
  output logic [7:0] cmdByte,
  input  logic       cmdDone,
  input  logic       cmdErr,
  input  logic [7:0] cmdRdData
);

  dpStrobe_t stb;
  logic      tmrLast;
  logic      readMatch;

  dps_control #(
    .RESET_PIN_PRESENT(RESET_PIN_PRESENT),
    .READ_PATH_PRESENT(READ_PATH_PRESENT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .condMode(condMode),
    .cmdDone(cmdDone), .cmdErr(cmdErr), .tmrLast(tmrLast), .readMatch(readMatch),
    .stb(stb), .cmdReq(cmdReq), .cmdRead(cmdRead), .busy(busy),
    .donePulse(donePulse), .doneStatus(doneStatus)
  );

  dps_datapath #(
    .CLK_HZ(CLK_HZ),
    .RESET_PIN_PRESENT(RESET_PIN_PRESENT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(cmdRdData),
    .tmrLast(tmrLast), .readMatch(readMatch), .cmdByte(cmdByte), .rstPinN(rstPinN)
  );

  AST_PIN_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> rstPinN); // R1
  AST_READ_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdRead) |-> (cmdByte == CMD_GET_PWR_MODE)); // R6
  AST_SOFT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && !cmdRead) |-> (cmdByte == CMD_SOFT_RESET)); // R4
  AST_NO_REQ_PIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !rstPinN |-> !cmdReq); // R2

endmodule

// File: tb/disp_pwrup_seq_tb.sv
module dps_bus_model #(parameter int LAT = 2) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdReq,
  input  logic       cmdRead,
  input  logic [7:0] cmdByte,
  input  logic [7:0] cfgRdVal,
  input  logic       cfgFailRead,
  input  logic       cfgFailSoft,
  output logic       cmdDone,
  output logic       cmdErr,
  output logic [7:0] rdData,
  output int         nCmd,
  output int         nRead,
  output logic [7:0] lastByte,
  output logic       lastWasRead
);
  int waitCnt;
  initial begin
    cmdDone = 1'b0; cmdErr = 1'b0; rdData = '0; nCmd = 0; nRead = 0;
    lastByte = '0; lastWasRead = 1'b0; waitCnt = 0;
  end
  always @(negedge clk) begin
    if (!rstN) begin
      cmdDone = 1'b0; cmdErr = 1'b0; waitCnt = 0;
    end else if (cmdDone) begin
      cmdDone = 1'b0; cmdErr = 1'b0;
    end else if (cmdReq) begin
      if (waitCnt == LAT) begin
        waitCnt = 0;
        cmdDone = 1'b1;
        nCmd++;
        lastByte = cmdByte;
        lastWasRead = cmdRead;
        if (cmdRead) begin
          nRead++;
          rdData = cfgRdVal;
          cmdErr = cfgFailRead;
        end else begin
          cmdErr = cfgFailSoft;
        end
      end else begin
        waitCnt++;
      end
    end
  end
endmodule

module disp_pwrup_seq_tb;
  localparam int unsigned CLK_MAIN = 100_000;
  localparam int unsigned CLK_FAST = 1_000;

  function automatic longint cyc(input longint hz, input longint us);
    longint c;
    c = (hz * us + 999_999) / 1_000_000;
    return (c == 0) ? 1 : c;
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] startV = '0, condV = '0;
  logic [2:0] busyV, doneV, pinV, reqV, rdV, cmdDoneV, cmdErrV, lastRdV;
  logic [2:0] cfgFailRd = '0, cfgFailSoft = '0;
  logic [1:0] statV [3];
  logic [7:0] byteV [3], rdDataV [3], lastByteV [3];
  logic [7:0] cfgRd [3];
  int nCmdV [3], nReadV [3];
  int doneCnt [3], pinLowCnt [3];
  int checks = 0, errors = 0;

  disp_pwrup_seq #(.CLK_HZ(CLK_MAIN), .RESET_PIN_PRESENT(1'b1), .READ_PATH_PRESENT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .start(startV[0]), .condMode(condV[0]), .busy(busyV[0]),
    .donePulse(doneV[0]), .doneStatus(statV[0]), .rstPinN(pinV[0]), .cmdReq(reqV[0]),
    .cmdRead(rdV[0]), .cmdByte(byteV[0]), .cmdDone(cmdDoneV[0]), .cmdErr(cmdErrV[0]),
    .cmdRdData(rdDataV[0]));
  disp_pwrup_seq #(.CLK_HZ(CLK_MAIN), .RESET_PIN_PRESENT(1'b0), .READ_PATH_PRESENT(1'b0)) u_nopin (
    .clk(clk), .rstN(rstN), .start(startV[1]), .condMode(condV[1]), .busy(busyV[1]),
    .donePulse(doneV[1]), .doneStatus(statV[1]), .rstPinN(pinV[1]), .cmdReq(reqV[1]),
    .cmdRead(rdV[1]), .cmdByte(byteV[1]), .cmdDone(cmdDoneV[1]), .cmdErr(cmdErrV[1]),
    .cmdRdData(rdDataV[1]));
  disp_pwrup_seq #(.CLK_HZ(CLK_FAST), .RESET_PIN_PRESENT(1'b1), .READ_PATH_PRESENT(1'b1)) u_fast (
    .clk(clk), .rstN(rstN), .start(startV[2]), .condMode(condV[2]), .busy(busyV[2]),
    .donePulse(doneV[2]), .doneStatus(statV[2]), .rstPinN(pinV[2]), .cmdReq(reqV[2]),
    .cmdRead(rdV[2]), .cmdByte(byteV[2]), .cmdDone(cmdDoneV[2]), .cmdErr(cmdErrV[2]),
    .cmdRdData(rdDataV[2]));

  for (genvar g = 0; g < 3; g++) begin : g_bus
    dps_bus_model #(.LAT(2)) u_bus (
      .clk(clk), .rstN(rstN), .cmdReq(reqV[g]), .cmdRead(rdV[g]), .cmdByte(byteV[g]),
      .cfgRdVal(cfgRd[g]), .cfgFailRead(cfgFailRd[g]), .cfgFailSoft(cfgFailSoft[g]),
      .cmdDone(cmdDoneV[g]), .cmdErr(cmdErrV[g]), .rdData(rdDataV[g]),
      .nCmd(nCmdV[g]), .nRead(nReadV[g]), .lastByte(lastByteV[g]), .lastWasRead(lastRdV[g]));
  end

  initial begin
    for (int i = 0; i < 3; i++) begin doneCnt[i] = 0; pinLowCnt[i] = 0; cfgRd[i] = '0; end
  end
  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (rstN && doneV[i]) doneCnt[i]++;
      if (rstN && !pinV[i]) pinLowCnt[i]++;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One sequence with cycle counts: pin-low samples, high-gap before the
  // soft-reset request, and samples from soft-reset completion to done.
  task automatic runSeq(input int idx, input bit cond, output int stOut,
                        output int lowC, output int gapC, output int setC);
    bit softDone = 0;
    int n = 0;
    lowC = 0; gapC = 0; setC = 0; stOut = -1;
    @(negedge clk);
    startV[idx] = 1'b1; condV[idx] = cond;
    @(negedge clk);
    startV[idx] = 1'b0;
    #1;
    check("R10", "busy after start", busyV[idx], 1);
    forever begin
      n++;
      if (!pinV[idx]) lowC++;
      else if (lowC > 0 && !reqV[idx] && !softDone) gapC++;
      if (softDone) setC++;
      else if (cmdDoneV[idx] && !lastRdV[idx]) softDone = 1;
      if (doneV[idx]) begin
        stOut = statV[idx];
        break;
      end
      if (n > 40000) begin
        check("R10", "sequence timeout", n, 0);
        break;
      end
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    check("R10", "done one cycle", doneV[idx], 0);
    check("R10", "idle after done", busyV[idx], 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    int st, lowC, gapC, setC, c0, r0, d0, p0;
    longint pM, wM, sM, sN, pF;
    pM = cyc(CLK_MAIN, 20); wM = cyc(CLK_MAIN, 120_000);
    sM = cyc(CLK_MAIN, 5_000); sN = cyc(CLK_MAIN, 120_000);
    pF = cyc(CLK_FAST, 20);

    repeat (3) @(negedge clk);
    #1;
    for (int i = 0; i < 3; i++) begin
      check("R1", "reset pin", pinV[i], 1);
      check("R1", "reset busy", busyV[i], 0);
      check("R1", "reset req", reqV[i], 0);
      check("R1", "reset done", doneV[i], 0);
    end
    rstN = 1'b1;

    // Unconditional full sequence: R2 R3 R4 R5 R9
    c0 = nCmdV[0]; r0 = nReadV[0];
    runSeq(0, 1'b0, st, lowC, gapC, setC);
    check("R2", "pin low cycles", lowC, pM);
    check("R3", "recover gap", gapC, wM);
    check("R5", "settle (pin) + done reg", setC, sM + 1);
    check("R4", "soft byte", lastByteV[0], 8'h01);
    check("R4", "commands", nCmdV[0] - c0, 1);
    check("R4", "reads", nReadV[0] - r0, 0);
    check("R9", "status reset done", st, 0);

    // Conditional, running display: R6
    cfgRd[0] = 8'h9F;
    c0 = nCmdV[0]; r0 = nReadV[0]; p0 = pinLowCnt[0];
    runSeq(0, 1'b1, st, lowC, gapC, setC);
    check("R6", "status already on", st, 1);
    check("R6", "only read issued", nCmdV[0] - c0, 1);
    check("R6", "read count", nReadV[0] - r0, 1);
    check("R6", "read code", lastByteV[0], 8'h0A);
    check("R6", "pin untouched", pinLowCnt[0] - p0, 0);

    // Conditional, display asleep: R7
    cfgRd[0] = 8'h3C;
    c0 = nCmdV[0];
    runSeq(0, 1'b1, st, lowC, gapC, setC);
    check("R7", "mismatch status", st, 0);
    check("R7", "mismatch commands", nCmdV[0] - c0, 2);
    check("R7", "mismatch pin low", lowC, pM);
    check("R7", "mismatch gap", gapC, wM);

    // Conditional, failed read with a running pattern: R7
    cfgRd[0] = 8'h1C; cfgFailRd[0] = 1'b1;
    c0 = nCmdV[0];
    runSeq(0, 1'b1, st, lowC, gapC, setC);
    check("R7", "read error status", st, 0);
    check("R7", "read error commands", nCmdV[0] - c0, 2);
    check("R7", "read error pin low", lowC, pM);
    cfgFailRd[0] = 1'b0;

    // Soft-reset failure: R9
    cfgFailSoft[0] = 1'b1;
    runSeq(0, 1'b0, st, lowC, gapC, setC);
    check("R9", "error status", st, 2);
    check("R9", "no settle wait", setC, 1);
    cfgFailSoft[0] = 1'b0;

    // Start while busy is ignored: R11
    cfgRd[0] = 8'h1C;
    c0 = nCmdV[0]; r0 = nReadV[0]; d0 = doneCnt[0];
    @(negedge clk); startV[0] = 1'b1; condV[0] = 1'b0;
    @(negedge clk); startV[0] = 1'b0;
    repeat (50) @(negedge clk);
    startV[0] = 1'b1; condV[0] = 1'b1;
    @(negedge clk); startV[0] = 1'b0; condV[0] = 1'b0;
    begin
      int n = 0;
      while (!doneV[0] && n < 40000) begin @(negedge clk); #1; n++; end
    end
    check("R11", "status", statV[0], 0);
    repeat (20) @(negedge clk);
    #1;
    check("R11", "single done", doneCnt[0] - d0, 1);
    check("R11", "no read", nReadV[0] - r0, 0);
    check("R11", "one command", nCmdV[0] - c0, 1);
    check("R11", "idle", busyV[0], 0);

    // No pin and no read path: R8 R12 R5
    c0 = nCmdV[1]; r0 = nReadV[1];
    runSeq(1, 1'b1, st, lowC, gapC, setC);
    check("R8", "no read issued", nReadV[1] - r0, 0);
    check("R8", "soft reset only", nCmdV[1] - c0, 1);
    check("R8", "status", st, 0);
    check("R12", "pin never low", pinLowCnt[1], 0);
    check("R5", "settle (no pin) + done reg", setC, sN + 1);

    // Sweep of every readback value on the fast instance: R6 R7
    for (int v = 0; v < 256; v++) begin
      bit run;
      cfgRd[2] = 8'(v);
      run = ((v & 8'h7C) == 8'h1C);
      c0 = nCmdV[2]; p0 = pinLowCnt[2];
      runSeq(2, 1'b1, st, lowC, gapC, setC);
      check(run ? "R6" : "R7", $sformatf("sweep 0x%02h status", v), st, run ? 1 : 0);
      check(run ? "R6" : "R7", $sformatf("sweep 0x%02h commands", v), nCmdV[2] - c0, run ? 1 : 2);
      check(run ? "R6" : "R7", $sformatf("sweep 0x%02h pin", v), pinLowCnt[2] - p0, run ? 0 : pF);
    end

    summary();
    $finish;
  end
endmodule